// File: doc/BRIEF.md
# Set-Associative Write-Back Cache

This block is a byte-wide cache placed between a processor-side request port and a block-wide main-memory port. Three parameters set its geometry: the number of sets, the number of lines in each set, and the bytes per line. Setting one line per set gives a direct-mapped cache.

Each request address is split into three fields. The low bits are the byte offset within a line. The bits just above them select a set. The remaining high bits form the tag. All lines of the selected set are compared with the tag in parallel. A hit returns the addressed byte one cycle after the request is accepted.

A miss is handled in three steps:
1. The cache chooses a victim line in the set.
2. If that line holds modified data, it is written back to memory as a whole block.
3. The block that holds the requested byte is fetched and installed.

Writes use write-allocate. A write that misses fetches the block first, merges the new byte into it, and marks the line dirty. Replacement prefers an empty line. When the set is full, the cache evicts the least recently used line.

Top module: `sa_cache`

## Requirements
- R1: The byte offset is addr[b-1:0], the set index is addr[b+s-1:b] and the tag is the top bits, where b = log2(bytes per line) and s = log2(sets). As a result, consecutive blocks fall in different sets, and a region of sets×lines×bytes contiguous bytes can be resident all at once.
- R2: A request hits only when a line in its set is valid and holds an equal tag. A hit reports rsp_hit=1.
- R3: A hit raises rsp_valid for one cycle, exactly one clock after acceptance. rsp_rdata is the byte at the offset for a read, and the written byte for a write.
- R4: A miss fetches the whole containing block from memory at block address addr>>b. It then answers with rsp_valid=1, rsp_hit=0, and the requested byte.
- R5: On a miss, the lowest-numbered invalid line of the set is filled in preference to any valid line.
- R6: When all lines of a set are valid, a miss replaces the line whose last hit or fill is the oldest in that set.
- R7: A write hit updates only the addressed byte, marks the line dirty, and causes no memory transaction.
- R8: A write miss fetches the block, merges the write byte into it, installs the line as dirty, and issues no memory write for an empty or clean victim.
- R9: A dirty victim is written to memory as a whole block at block address {old tag, set} before the fetch of the new block begins. The data it carries is the data written earlier.
- R10: A clean victim is dropped without any memory write.
- R11: After reset every line is invalid and req_ready is 1. req_ready stays 0 while a write-back or fetch is in progress.
- R12: With 4-bit addresses and 2-byte lines, the read trace 0,1,7,8,0 from reset gives the following: miss,hit,miss,miss,miss for 4 sets of 1 line, and miss,hit,miss,miss,hit for 2 sets of 2 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served without memory traffic |
| rsp_rdata | output | 8 | Read byte (or the written byte for writes) |
| mem_req | output | 1 | Memory transaction pending, held until mem_ack |
| mem_write | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | ADDR_W-log2(BLOCK_BYTES) | Block address |
| mem_wdata | output | 8*BLOCK_BYTES | Write-back block |
| mem_rdata | input | 8*BLOCK_BYTES | Fetched block, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the pending transaction |

## Verification
A hit must produce its response strobe on the first clock after acceptance. A miss answers on the clock after the final memory acknowledge; when a write-back comes first, that means after two acknowledges. The bench drives each request and then samples at every falling edge that follows acceptance. It counts the cycles until the strobe and requires the count to be exactly one for every hit. Miss responses are accepted whenever they arrive. For those, the memory model's read and write counters and the last write-back address are checked after each operation.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } cache_state_e;
endpackage

// File: rtl/cache_match.sv
module cache_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       valid_vec,
  input  logic [WAYS*TAG_W-1:0] tag_flat,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [WAY_W-1:0]      lru_way,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      victim_way
);
  logic             free_found;
  logic [WAY_W-1:0] free_way;

  // parallel compare of every line in the selected set
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_vec[w] && (tag_flat[w*TAG_W +: TAG_W] == req_tag);
  end

  always_comb begin
    hit_way    = '0;
    free_way   = '0;
    free_found = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!valid_vec[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  assign hit        = |hit_vec;
  assign victim_way = free_found ? free_way : lru_way;
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS  = 2,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // per-line age rank: 0 = most recent, WAYS-1 = next victim
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_d [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  always_comb begin
    age_d = age_q;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way) begin
        age_d[touch_set][w] = '0;
      end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
        age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_vec[w] = (age_q[touch_set][w] == OLDEST);
      if (oldest_vec[w]) lru_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  // ranks stay a permutation: exactly one oldest line per set
  assert_lru_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SETS        = 2,
  parameter int WAYS        = 2,
  parameter int BLOCK_BYTES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [7:0]                            req_wdata,
  output logic                                  rsp_valid,
  output logic                                  rsp_hit,
  output logic [7:0]                            rsp_rdata,
  output logic                                  mem_req,
  output logic                                  mem_write,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] mem_addr,
  output logic [8*BLOCK_BYTES-1:0]              mem_wdata,
  input  logic [8*BLOCK_BYTES-1:0]              mem_rdata,
  input  logic                                  mem_ack
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int BLK_W = 8 * BLOCK_BYTES;

  cache_state_e state_q, state_d;

  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_wr_q;
  logic [7:0]        pend_wdata_q;
  logic [WAY_W-1:0]  victim_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [BLK_W-1:0]  data_q  [SETS][WAYS];

  logic [WAYS*TAG_W-1:0] tag_flat;
  logic [WAYS-1:0]       hit_vec;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, victim_way, lru_way, touch_way, line_way;

  logic accept, hit_acc, miss_acc, fill_done, victim_dirty, touch_en;
  logic line_we, line_dirty;
  logic [BLK_W-1:0] fill_blk, hit_blk, line_blk;
  logic rsp_valid_q, rsp_hit_q, rsp_valid_d, rsp_hit_d;
  logic [7:0] rsp_rdata_q, rsp_rdata_d;

  // address split: tag | set (middle bits) | offset
  assign req_ready = (state_q == ST_IDLE);
  assign cur_addr  = req_ready ? req_addr : pend_addr_q;
  assign cur_off   = cur_addr[OFF_W-1:0];
  assign set_idx   = cur_addr[OFF_W +: SET_W];
  assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign tag_flat[w*TAG_W +: TAG_W] = tag_q[set_idx][w];
  end

  cache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_vec (valid_q[set_idx]),
    .tag_flat  (tag_flat),
    .req_tag   (cur_tag),
    .lru_way   (lru_way),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way),
    .victim_way(victim_way)
  );

  cache_lru #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W), .SET_W(SET_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch_en (touch_en),
    .touch_set(set_idx),
    .touch_way(touch_way),
    .lru_way  (lru_way)
  );

  assign accept       = req_valid && req_ready;
  assign hit_acc      = accept && hit;
  assign miss_acc     = accept && !hit;
  assign fill_done    = (state_q == ST_FILL) && mem_ack;
  assign victim_dirty = valid_q[set_idx][victim_way] && dirty_q[set_idx][victim_way];

  // memory side
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_write = (state_q == ST_WB);
  assign mem_addr  = mem_write ? {tag_q[set_idx][victim_q], set_idx}
                               : pend_addr_q[ADDR_W-1:OFF_W];
  assign mem_wdata = data_q[set_idx][victim_q];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_acc) state_d = victim_dirty ? ST_WB : ST_FILL;
      ST_WB:   if (mem_ack)  state_d = ST_FILL;
      ST_FILL: if (mem_ack)  state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // line update and response next-state
  always_comb begin
    fill_blk = mem_rdata;
    if (pend_wr_q) fill_blk[{cur_off, 3'b000} +: 8] = pend_wdata_q;
    hit_blk = data_q[set_idx][hit_way];
    hit_blk[{cur_off, 3'b000} +: 8] = req_wdata;

    line_we    = fill_done || (hit_acc && req_write);
    line_way   = fill_done ? victim_q : hit_way;
    line_blk   = fill_done ? fill_blk : hit_blk;
    line_dirty = fill_done ? pend_wr_q : 1'b1;

    touch_en  = hit_acc || fill_done;
    touch_way = fill_done ? victim_q : hit_way;

    rsp_valid_d = touch_en;
    rsp_hit_d   = hit_acc;
    if (fill_done)      rsp_rdata_d = fill_blk[{cur_off, 3'b000} +: 8];
    else if (req_write) rsp_rdata_d = req_wdata;
    else                rsp_rdata_d = data_q[set_idx][hit_way][{cur_off, 3'b000} +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      if (line_we) begin
        valid_q[set_idx][line_way] <= 1'b1;
        dirty_q[set_idx][line_way] <= line_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (miss_acc) begin
      pend_addr_q  <= req_addr;
      pend_wr_q    <= req_write;
      pend_wdata_q <= req_wdata;
      victim_q     <= victim_way;
    end
    if (line_we)   data_q[set_idx][line_way] <= line_blk;
    if (fill_done) tag_q[set_idx][line_way]  <= cur_tag;
    if (touch_en)  rsp_rdata_q <= rsp_rdata_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_rdata = rsp_rdata_q;

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit) |=> (rsp_valid && rsp_hit));
  assert_mem_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));
  assert_fill_answers_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_write && mem_ack) |=> (rsp_valid && !rsp_hit));
  assert_wb_then_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write));
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: tb/sa_cache_tb_top.sv
module cache_mem_model #(
  parameter int ADDR_W = 4,
  parameter int BB     = 2,
  parameter int LAT    = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mem_req,
  input  logic                         mem_write,
  input  logic [ADDR_W-$clog2(BB)-1:0] mem_addr,
  input  logic [8*BB-1:0]              mem_wdata,
  output logic [8*BB-1:0]              mem_rdata,
  output logic                         mem_ack,
  output int                           wr_count,
  output int                           rd_count,
  output int                           last_wb
);
  logic [7:0] mem [2**ADDR_W];
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack  <= 1'b0;
      cnt      <= 0;
      wr_count <= 0;
      rd_count <= 0;
      last_wb  <= -1;
      for (int a = 0; a < 2**ADDR_W; a++) mem[a] <= 8'(a * 13 + 5);
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_req) begin
      if (cnt == LAT) begin
        mem_ack <= 1'b1;
        if (mem_write) begin
          for (int k = 0; k < BB; k++) mem[int'(mem_addr) * BB + k] <= mem_wdata[8*k +: 8];
          wr_count <= wr_count + 1;
          last_wb  <= int'(mem_addr);
        end else begin
          for (int k = 0; k < BB; k++) mem_rdata[8*k +: 8] <= mem[int'(mem_addr) * BB + k];
          rd_count <= rd_count + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module sa_cache_tb_top;
  localparam int AW = 4;
  localparam int BB = 2;
  localparam int MW = AW - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic va, vb, req_write;
  logic [AW-1:0] req_addr;
  logic [7:0] req_wdata;

  logic a_ready, a_rsp_valid, a_rsp_hit, a_mreq, a_mwr, a_ack;
  logic [7:0] a_rdata;
  logic [MW-1:0] a_maddr;
  logic [8*BB-1:0] a_mwd, a_mrd;
  int a_wr, a_rd, a_lastwb;

  logic b_ready, b_rsp_valid, b_rsp_hit, b_mreq, b_mwr, b_ack;
  logic [7:0] b_rdata;
  logic [MW-1:0] b_maddr;
  logic [8*BB-1:0] b_mwd, b_mrd;
  int b_wr, b_rd, b_lastwb;

  sa_cache #(.ADDR_W(AW), .SETS(2), .WAYS(2), .BLOCK_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(va), .req_ready(a_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(a_rsp_valid), .rsp_hit(a_rsp_hit),
    .rsp_rdata(a_rdata), .mem_req(a_mreq), .mem_write(a_mwr), .mem_addr(a_maddr),
    .mem_wdata(a_mwd), .mem_rdata(a_mrd), .mem_ack(a_ack));

  cache_mem_model #(.ADDR_W(AW), .BB(BB), .LAT(3)) mem_a_i (
    .clk(clk), .rst_n(rst_n), .mem_req(a_mreq), .mem_write(a_mwr), .mem_addr(a_maddr),
    .mem_wdata(a_mwd), .mem_rdata(a_mrd), .mem_ack(a_ack), .wr_count(a_wr),
    .rd_count(a_rd), .last_wb(a_lastwb));

  sa_cache #(.ADDR_W(AW), .SETS(4), .WAYS(1), .BLOCK_BYTES(BB)) dut_dm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(vb), .req_ready(b_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(b_rsp_valid), .rsp_hit(b_rsp_hit),
    .rsp_rdata(b_rdata), .mem_req(b_mreq), .mem_write(b_mwr), .mem_addr(b_maddr),
    .mem_wdata(b_mwd), .mem_rdata(b_mrd), .mem_ack(b_ack));

  cache_mem_model #(.ADDR_W(AW), .BB(BB), .LAT(2)) mem_b_i (
    .clk(clk), .rst_n(rst_n), .mem_req(b_mreq), .mem_write(b_mwr), .mem_addr(b_maddr),
    .mem_wdata(b_mwd), .mem_rdata(b_mrd), .mem_ack(b_ack), .wr_count(b_wr),
    .rd_count(b_rd), .last_wb(b_lastwb));

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] ref_mem [16];

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a * 13 + 5);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; va = 1'b0; vb = 1'b0;
    req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int a = 0; a < 16; a++) ref_mem[a] = init_byte(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // eh_a / eh_b: expected hit (1), miss (0) or not checked (-1)
  task automatic access(input string tag, input bit wr, input int addr, input int wd,
                        input int eh_a, input int eh_b);
    bit ga = 0, gb = 0, aa, ab, ha = 0, hb = 0;
    int la = 0, lb = 0, n = 0;
    logic [7:0] da = '0, db = '0, exp_d;
    req_write = wr; req_addr = AW'(addr); req_wdata = 8'(wd);
    va = 1'b1; vb = 1'b1;
    while (!(ga && gb) && n < 400) begin
      aa = va && a_ready;
      ab = vb && b_ready;
      @(posedge clk);
      @(negedge clk);
      n++;
      if (aa) va = 1'b0;
      if (ab) vb = 1'b0;
      if (!va && !ga) begin
        la++;
        if (a_rsp_valid) begin ga = 1; ha = a_rsp_hit; da = a_rdata; end
      end
      if (!vb && !gb) begin
        lb++;
        if (b_rsp_valid) begin gb = 1; hb = b_rsp_hit; db = b_rdata; end
      end
    end
    va = 1'b0; vb = 1'b0;
    if (!(ga && gb)) begin
      n_chk++; n_fail++;
      $display("FAIL %s: no response at addr %0d, actual %0d expected 1", tag, addr, 0);
    end
    exp_d = wr ? 8'(wd) : ref_mem[addr];
    if (wr) ref_mem[addr] = 8'(wd);
    chk({tag, " data 2-way"}, int'(da), int'(exp_d));
    chk({tag, " data direct"}, int'(db), int'(exp_d));
    if (eh_a >= 0) chk({tag, " hit 2-way"}, int'(ha), eh_a);
    if (eh_b >= 0) chk({tag, " hit direct"}, int'(hb), eh_b);
    if (ha) chk("R3 hit latency 2-way", la, 1);
    if (hb) chk("R3 hit latency direct", lb, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R11: ready and quiet after reset
    chk("R11 ready 2-way", int'(a_ready), 1);
    chk("R11 ready direct", int'(b_ready), 1);
    chk("R11 no response", int'(a_rsp_valid | b_rsp_valid), 0);

    // R12 trace (R2 hit, R5 invalid-first)
    access("R12", 0, 0, 0, 0, 0);
    access("R2", 0, 1, 0, 1, 1);
    access("R12", 0, 7, 0, 0, 0);
    access("R12", 0, 8, 0, 0, 0);
    access("R5", 0, 0, 0, 1, 0);

    // R6: LRU order in set 0 of the 2-way cache
    access("R6", 0, 12, 0, 0, -1);
    access("R6", 0, 0, 0, 1, -1);
    access("R6", 0, 8, 0, 0, -1);
    access("R6", 0, 0, 0, 1, -1);
    access("R6", 0, 12, 0, 0, -1);
    access("R6", 0, 8, 0, 0, -1);
    chk("R10 no write-back of clean lines", a_wr, 0);

    // write paths
    do_reset();
    access("R11 cold after reset", 0, 0, 0, 0, 0);
    chk("R4 one block fetch", a_rd, 1);
    access("R4", 0, 4, 0, 0, 0);
    access("R7", 1, 5, 'hA5, 1, 1);
    chk("R7 no memory traffic reads", a_rd, 2);
    chk("R7 no memory traffic writes", a_wr, 0);
    access("R7", 0, 5, 0, 1, 1);
    access("R8", 1, 2, 'h3C, 0, -1);
    chk("R8 fetch on write miss", a_rd, 3);
    chk("R8 no write-back", a_wr, 0);
    access("R8", 0, 2, 0, 1, -1);
    access("R8", 0, 3, 0, 1, -1);
    access("R10", 0, 8, 0, 0, -1);
    chk("R10 clean victim dropped", a_wr, 0);
    access("R9", 0, 12, 0, 0, -1);
    chk("R9 write-back count", a_wr, 1);
    chk("R9 write-back block address", a_lastwb, 2);
    chk("R9 written byte in memory", int'(mem_a_i.mem[5]), 'hA5);
    chk("R9 untouched byte in memory", int'(mem_a_i.mem[4]), int'(init_byte(4)));
    access("R9", 0, 5, 0, 0, -1);

    // R1: sweeps show middle-bit indexing
    do_reset();
    for (int a = 0; a < 8; a++) access("R1", 0, a, 0, a % 2, a % 2);
    for (int a = 0; a < 8; a++) access("R1 resident", 0, a, 0, 1, 1);
    for (int a = 8; a < 16; a++) access("R1", 0, a, 0, a % 2, a % 2);

    // write sweep then read back through evictions
    for (int a = 0; a < 16; a++) access("R8", 1, a, (a * 29 + 'h47) % 256, -1, -1);
    for (int a = 0; a < 16; a++) access("R9", 0, a, 0, -1, -1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule